// File: doc/BRIEF.md
# Root and Context Entry Fetcher

This block resolves a requester identity (an 8-bit bus number plus an 8-bit device/function number) into its context entry. It fetches the 128-bit root entry for the bus from a root table in memory, selects the half of that entry that applies to the function, then fetches a context entry of 128 bits (legacy layout) or 256 bits (scalable layout). On the way it applies presence and reserved-bit rules, and it ends every lookup with one fault code chosen by a fixed priority.

The root table base and the layout selector live in a small 64-bit root pointer register inside the block. Written values take effect only when the pointer is latched, and the scalable layout is in force only if a mode-enable input and the layout bit of the register are both set at that moment. Memory is reached through a 64-bit read port with one read in flight at a time. In the scalable layout the final validation of the context entry is delegated to an external checker through a valid/done handshake.

Top module: `ctx_entry_fetcher`

## Requirements
- R1: The root pointer register resets to zero. Bits 9:0 always read zero and bits 63:10 take the written value.
- R2: On a latch pulse the block captures the table base (register bits AW-1:12) and sets scalable mode to sm_enable AND register bit 10. A lookup uses the base and mode that were latched before the cycle in which it is accepted, so a latch in the same cycle affects only later lookups. rsp_scalable reports the mode used.
- R3: The root entry is read as two 64-bit beats at base + bus*16 (low half) and base + bus*16 + 8 (high half). All reads are 8-byte aligned and a new read is issued only after the previous one has returned.
- R4: In scalable mode a devfn of 128 or more uses the present bit (bit 0) and context pointer (bits AW-1:12) of the high half with index devfn[6:0]. Otherwise the low half and the full devfn are used.
- R5: A context entry is read from pointer + index*16 (two beats) in legacy mode and from pointer + index*32 (four beats) in scalable mode. On success rsp_ctx_lo and rsp_ctx_hi carry context words 0 and 1.
- R6: Root reserved bits are 11:1 and 63:AW of a half. In legacy mode the high half must be all zero and the low half free of reserved bits. In scalable mode neither half may have a reserved bit set.
- R7: A context entry with a reserved bit set is rejected. Legacy: word 0 bits 11:4 and 63:AW, word 1 bits 7:3 and 63:24. Scalable: word 0 bits 11:2 and 63:AW, word 1 bits 63:20, and all of words 2 and 3.
- R8: rsp_fault gives the first failure in this order: 1 root read error, 2 root not present, 3 root reserved, 4 context read error, 5 context not present (word 0 bit 0 clear), 6 context reserved, then 7 legacy invalid or 8 scalable check refused. Zero means success.
- R9: In legacy mode the width field is word 1 bits 2:0. A field not enabled in the SAGAW mask, or a type field (word 0 bits 3:2) of 3, or of 2 while pass-through is disabled, gives code 7. On success rsp_level = 2 + field and rsp_width = 30 + 9*field.
- R10: In scalable mode a context entry that passes R7 raises pchk_valid until pchk_done. pchk_ok low then gives code 8, high gives 0. Legacy lookups never raise pchk_valid.
- R11: req_ready is high only while no lookup is in progress. rsp_valid is a one-cycle pulse that ends each lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rtaddr_we | input | 1 | Write strobe for the root pointer register |
| rtaddr_wdata | input | 64 | Write data for the root pointer register |
| rtaddr_rdata | output | 64 | Current root pointer register value |
| root_latch | input | 1 | Latch the table base and mode from the register |
| sm_enable | input | 1 | Allows scalable mode |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_bus | input | 8 | Bus number of the requester |
| req_devfn | input | 8 | Device/function number of the requester |
| mem_rd_valid | output | 1 | Read request, one cycle |
| mem_rd_addr | output | 64 | Byte address of the 64-bit read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Read data |
| mem_rsp_err | input | 1 | Read failed |
| pchk_valid | output | 1 | Scalable context entry waits for external check |
| pchk_done | input | 1 | External check finished |
| pchk_ok | input | 1 | External check accepted the entry |
| rsp_valid | output | 1 | Lookup result pulse |
| rsp_fault | output | 4 | Fault code, 0 on success |
| rsp_ctx_lo | output | 64 | Context word 0 |
| rsp_ctx_hi | output | 64 | Context word 1 |
| rsp_scalable | output | 1 | Mode the lookup used |
| rsp_level | output | 4 | Legacy table level on success |
| rsp_width | output | 7 | Legacy address width on success |

## Verification
The two functions that can meet in one cycle are the latch of a new root pointer and the acceptance of a lookup request. The bench first writes a register value that turns scalable mode on, then raises root_latch and req_valid together, using a root entry whose high half is non-zero and a devfn above 127: under the old legacy mode that lookup must end with the root reserved fault and rsp_scalable low, while the next lookup of the same requester must succeed in scalable mode through the high half. Seeing both outcomes in that order shows that the lookup captured the pointer and mode before the latch, and that the latch still took effect.

// File: rtl/ctxf_pkg.sv
// Package: shared fault codes and state encoding of the context entry fetcher.
// Assumes: fault code values are visible to software and must stay fixed.
package ctxf_pkg;

    typedef enum logic [3:0] {
        FLT_NONE      = 4'd0,
        FLT_ROOT_RD   = 4'd1,
        FLT_ROOT_NP   = 4'd2,
        FLT_ROOT_RSVD = 4'd3,
        FLT_CTX_RD    = 4'd4,
        FLT_CTX_NP    = 4'd5,
        FLT_CTX_RSVD  = 4'd6,
        FLT_CTX_INV   = 4'd7,
        FLT_PASID     = 4'd8
    } flt_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RISSUE,
        ST_RWAIT,
        ST_RCHK,
        ST_CISSUE,
        ST_CWAIT,
        ST_CCHK,
        ST_PCHK,
        ST_DONE
    } st_e;

endpackage

// File: rtl/ctxf_root_ptr.sv
// Module: root pointer register plus the latched table base and mode.
// Does: holds the software-visible pointer (low 10 bits hard-wired to zero)
//       and, on a latch pulse, copies the base and scalable mode from it.
// Assumes: a latch sees the register value held before that cycle's write.
module ctxf_root_ptr #(
    parameter int AW = 39
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [63:0] wr_data,
    input  logic        latch,
    input  logic        sm_enable,
    output logic [63:0] reg_q,
    output logic [63:0] base_q,
    output logic        scal_q
);
    localparam logic [63:0] ADDR_MASK = ((64'd1 << AW) - 64'd1) & ~64'hFFF;
    localparam int          SMT_BIT   = 10;

    // Software register: bits 63:10 writable, bits 9:0 forced to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)     reg_q <= '0;
        else if (wr_en) reg_q <= {wr_data[63:10], 10'b0};
    end

    // Latched pointer and mode, refreshed only on a latch pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            scal_q <= 1'b0;
        end else if (latch) begin
            base_q <= reg_q & ADDR_MASK;
            scal_q <= sm_enable & reg_q[SMT_BIT];
        end
    end
endmodule

// File: rtl/ctxf_root_check.sv
// Module: combinational decode of a fetched root entry.
// Does: selects the half that serves the function, derives the context
//       pointer and index, and applies the per-mode reserved-bit rule.
// Assumes: both halves have been fetched before the outputs are used.
module ctxf_root_check #(
    parameter int AW = 39
) (
    input  logic [63:0] lo,
    input  logic [63:0] hi,
    input  logic        scal,
    input  logic [7:0]  devfn,
    output logic        present,
    output logic        rsvd,
    output logic [63:0] ctp,
    output logic [7:0]  idx
);
    localparam logic [63:0] ADDR_MASK = ((64'd1 << AW) - 64'd1) & ~64'hFFF;
    localparam logic [63:0] RSVD_MASK = ~((64'd1 << AW) - 64'd1) | 64'hFFE;

    logic        use_hi;
    logic [63:0] half;

    // Half selection, pointer and index derivation.
    always_comb begin
        use_hi  = scal & devfn[7];
        half    = use_hi ? hi : lo;
        present = half[0];
        ctp     = half & ADDR_MASK;
        idx     = use_hi ? {1'b0, devfn[6:0]} : devfn;
    end

    // Reserved-bit rule: legacy needs a zero high half, scalable checks both.
    always_comb begin
        if (scal) rsvd = (|(lo & RSVD_MASK)) | (|(hi & RSVD_MASK));
        else      rsvd = (|hi) | (|(lo & RSVD_MASK));
    end
endmodule

// File: rtl/ctxf_ctx_check.sv
// Module: combinational checks of a fetched context entry.
// Does: presence, per-mode reserved bits, legacy level and type checks,
//       and the legacy level and address width derived from the entry.
// Assumes: words 2 and 3 are zero-filled for legacy lookups.
module ctxf_ctx_check #(
    parameter int         AW    = 39,
    parameter logic [7:0] SAGAW = 8'h06,
    parameter bit         PT_OK = 1'b1
) (
    input  logic [63:0] w0,
    input  logic [63:0] w1,
    input  logic [63:0] w2,
    input  logic [63:0] w3,
    input  logic        scal,
    output logic        present,
    output logic        rsvd,
    output logic        invalid,
    output logic [3:0]  level,
    output logic [6:0]  width
);
    localparam logic [63:0] HIGH_MASK = ~((64'd1 << AW) - 64'd1);
    localparam logic [63:0] L_W0_RSVD = HIGH_MASK | 64'hFF0;
    localparam logic [63:0] L_W1_RSVD = 64'hFFFF_FFFF_FF00_00F8;
    localparam logic [63:0] S_W0_RSVD = HIGH_MASK | 64'hFFC;
    localparam logic [63:0] S_W1_RSVD = 64'hFFFF_FFFF_FFF0_0000;

    logic [2:0] aw_fld;
    logic [1:0] tt;
    logic       level_ok;
    logic       type_ok;

    // Presence and reserved bits per layout.
    always_comb begin
        present = w0[0];
        if (scal) rsvd = (|(w0 & S_W0_RSVD)) | (|(w1 & S_W1_RSVD)) | (|w2) | (|w3);
        else      rsvd = (|(w0 & L_W0_RSVD)) | (|(w1 & L_W1_RSVD));
    end

    // Legacy level and type validation with derived level and width.
    always_comb begin
        aw_fld   = w1[2:0];
        tt       = w0[3:2];
        level_ok = SAGAW[aw_fld];
        type_ok  = (tt == 2'd0) || (tt == 2'd1) || ((tt == 2'd2) && PT_OK);
        invalid  = !scal && !(level_ok && type_ok);
        level    = scal ? 4'd0 : 4'd2 + {1'b0, aw_fld};
        width    = scal ? 7'd0 : 7'd30 + 7'd9 * {4'd0, aw_fld};
    end
endmodule

// File: rtl/ctx_entry_fetcher.sv
// Module: top of the root and context entry fetcher.
// Does: accepts one lookup at a time, reads the root entry and the context
//       entry over a single-outstanding 64-bit read port, and reports a
//       prioritised fault code; scalable entries pass an external check.
// Assumes: the memory answers every read exactly once; no read backpressure.
module ctx_entry_fetcher
    import ctxf_pkg::*;
#(
    parameter int         AW    = 39,
    parameter logic [7:0] SAGAW = 8'h06,
    parameter bit         PT_OK = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rtaddr_we,
    input  logic [63:0] rtaddr_wdata,
    output logic [63:0] rtaddr_rdata,
    input  logic        root_latch,
    input  logic        sm_enable,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [7:0]  req_bus,
    input  logic [7:0]  req_devfn,
    output logic        mem_rd_valid,
    output logic [63:0] mem_rd_addr,
    input  logic        mem_rsp_valid,
    input  logic [63:0] mem_rsp_data,
    input  logic        mem_rsp_err,
    output logic        pchk_valid,
    input  logic        pchk_done,
    input  logic        pchk_ok,
    output logic        rsp_valid,
    output logic [3:0]  rsp_fault,
    output logic [63:0] rsp_ctx_lo,
    output logic [63:0] rsp_ctx_hi,
    output logic        rsp_scalable,
    output logic [3:0]  rsp_level,
    output logic [6:0]  rsp_width
);
    localparam int ROOT_BEATS = 2;
    localparam int CTX_WORDS  = 4;

    st_e         st;
    flt_e        fault_q;
    logic [7:0]  bus_q, devfn_q;
    logic [63:0] base_l;
    logic        scal_l;
    logic [1:0]  beat;
    logic        err_q;
    logic [63:0] root_w [ROOT_BEATS];
    logic [63:0] ctx_w  [CTX_WORDS];

    logic [63:0] base_q;
    logic        scal_q;
    logic        r_present, r_rsvd;
    logic [63:0] ctp;
    logic [7:0]  idx;
    logic        c_present, c_rsvd, c_invalid;
    logic [1:0]  ctx_last;

    ctxf_root_ptr #(.AW(AW)) u_ptr (
        .clk(clk), .rst_n(rst_n), .wr_en(rtaddr_we), .wr_data(rtaddr_wdata),
        .latch(root_latch), .sm_enable(sm_enable),
        .reg_q(rtaddr_rdata), .base_q(base_q), .scal_q(scal_q)
    );

    ctxf_root_check #(.AW(AW)) u_root (
        .lo(root_w[0]), .hi(root_w[1]), .scal(scal_l), .devfn(devfn_q),
        .present(r_present), .rsvd(r_rsvd), .ctp(ctp), .idx(idx)
    );

    ctxf_ctx_check #(.AW(AW), .SAGAW(SAGAW), .PT_OK(PT_OK)) u_ctx (
        .w0(ctx_w[0]), .w1(ctx_w[1]), .w2(ctx_w[2]), .w3(ctx_w[3]),
        .scal(scal_l), .present(c_present), .rsvd(c_rsvd),
        .invalid(c_invalid), .level(rsp_level), .width(rsp_width)
    );

    // Last context beat depends on the layout in force for this lookup.
    assign ctx_last = scal_l ? 2'd3 : 2'd1;

    // Read address: root beats from the bus slot, context beats from the entry slot.
    always_comb begin
        if (st == ST_RISSUE)
            mem_rd_addr = base_l + {52'b0, bus_q, 4'b0} + {59'b0, beat, 3'b0};
        else if (scal_l)
            mem_rd_addr = ctp + {51'b0, idx, 5'b0} + {59'b0, beat, 3'b0};
        else
            mem_rd_addr = ctp + {52'b0, idx, 4'b0} + {59'b0, beat, 3'b0};
    end

    // Handshake and result outputs decoded from the state.
    always_comb begin
        req_ready    = (st == ST_IDLE);
        mem_rd_valid = (st == ST_RISSUE) || (st == ST_CISSUE);
        pchk_valid   = (st == ST_PCHK);
        rsp_valid    = (st == ST_DONE);
        rsp_fault    = fault_q;
        rsp_ctx_lo   = ctx_w[0];
        rsp_ctx_hi   = ctx_w[1];
        rsp_scalable = scal_l;
    end

    // Lookup sequencer: root fetch, root checks, context fetch, checks, result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            fault_q <= FLT_NONE;
            bus_q   <= '0;
            devfn_q <= '0;
            base_l  <= '0;
            scal_l  <= 1'b0;
            beat    <= '0;
            err_q   <= 1'b0;
            for (int i = 0; i < ROOT_BEATS; i++) root_w[i] <= '0;
            for (int i = 0; i < CTX_WORDS; i++)  ctx_w[i]  <= '0;
        end else begin
            case (st)
                ST_IDLE: if (req_valid) begin
                    bus_q   <= req_bus;
                    devfn_q <= req_devfn;
                    base_l  <= base_q;
                    scal_l  <= scal_q;
                    beat    <= '0;
                    err_q   <= 1'b0;
                    fault_q <= FLT_NONE;
                    for (int i = 0; i < CTX_WORDS; i++) ctx_w[i] <= '0;
                    st      <= ST_RISSUE;
                end
                ST_RISSUE: st <= ST_RWAIT;
                ST_RWAIT: if (mem_rsp_valid) begin
                    root_w[beat[0]] <= mem_rsp_data;
                    err_q           <= err_q | mem_rsp_err;
                    if (beat == 2'(ROOT_BEATS - 1)) st <= ST_RCHK;
                    else begin
                        beat <= beat + 2'd1;
                        st   <= ST_RISSUE;
                    end
                end
                ST_RCHK: begin
                    beat  <= '0;
                    err_q <= 1'b0;
                    if (err_q)           begin fault_q <= FLT_ROOT_RD;   st <= ST_DONE; end
                    else if (!r_present) begin fault_q <= FLT_ROOT_NP;   st <= ST_DONE; end
                    else if (r_rsvd)     begin fault_q <= FLT_ROOT_RSVD; st <= ST_DONE; end
                    else                 st <= ST_CISSUE;
                end
                ST_CISSUE: st <= ST_CWAIT;
                ST_CWAIT: if (mem_rsp_valid) begin
                    ctx_w[beat] <= mem_rsp_data;
                    err_q       <= err_q | mem_rsp_err;
                    if (beat == ctx_last) st <= ST_CCHK;
                    else begin
                        beat <= beat + 2'd1;
                        st   <= ST_CISSUE;
                    end
                end
                ST_CCHK: begin
                    if (err_q)           begin fault_q <= FLT_CTX_RD;   st <= ST_DONE; end
                    else if (!c_present) begin fault_q <= FLT_CTX_NP;   st <= ST_DONE; end
                    else if (c_rsvd)     begin fault_q <= FLT_CTX_RSVD; st <= ST_DONE; end
                    else if (scal_l)     st <= ST_PCHK;
                    else if (c_invalid)  begin fault_q <= FLT_CTX_INV;  st <= ST_DONE; end
                    else                 st <= ST_DONE;
                end
                ST_PCHK: if (pchk_done) begin
                    fault_q <= pchk_ok ? FLT_NONE : FLT_PASID;
                    st      <= ST_DONE;
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ctxf_checker.sv
// Module: protocol checker for the context entry fetcher, bound to the top.
// Does: watches the read port, the external check handshake and the result.
// Assumes: attached through the bind statement at the end of this file.
module ctxf_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [63:0] rtaddr_rdata,
    input logic        req_ready,
    input logic        mem_rd_valid,
    input logic [63:0] mem_rd_addr,
    input logic        mem_rsp_valid,
    input logic        pchk_valid,
    input logic        pchk_done,
    input logic        pchk_ok,
    input logic        rsp_valid,
    input logic [3:0]  rsp_fault,
    input logic        rsp_scalable
);
    logic busy;

    // Tracks whether a read is outstanding on the memory port.
    always_ff @(posedge clk) begin
        if (!rst_n)             busy <= 1'b0;
        else if (mem_rsp_valid) busy <= 1'b0;
        else if (mem_rd_valid)  busy <= 1'b1;
    end

    assert_low_bits_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rtaddr_rdata[9:0] == 10'd0);

    assert_pchk_scalable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pchk_valid |-> rsp_scalable);

    assert_read_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> mem_rd_addr[2:0] == 3'd0);

    assert_single_outstanding_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> !busy);

    assert_refused_check_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pchk_valid && pchk_done && !pchk_ok) |=> (rsp_valid && rsp_fault == 4'd8));

    assert_no_pasid_fault_legacy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_scalable) |-> rsp_fault != 4'd8);

    assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || mem_rd_valid || pchk_valid) |-> !req_ready);
endmodule

bind ctx_entry_fetcher ctxf_checker u_ctxf_checker (
    .clk(clk), .rst_n(rst_n), .rtaddr_rdata(rtaddr_rdata), .req_ready(req_ready),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .pchk_valid(pchk_valid),
    .pchk_done(pchk_done), .pchk_ok(pchk_ok), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_scalable(rsp_scalable)
);

// File: tb/ctx_entry_fetcher_tb.sv
`timescale 1ns/1ps
// Bench: vector table of lookups walked by one loop, then directed tests.
module ctx_entry_fetcher_tb;
    localparam logic [63:0] RB  = 64'h0000_0000_0010_0000;
    localparam logic [63:0] TA  = 64'h0000_0000_0020_0000;
    localparam logic [63:0] TB  = 64'h0000_0000_0030_0000;
    localparam logic [63:0] L0  = 64'h0000_0000_0040_0001;
    localparam logic [63:0] L1  = 64'h0000_0000_0000_0501;
    localparam logic [63:0] S0  = 64'h0000_0000_0050_0003;
    localparam logic [63:0] PM  = 64'h0000_007F_FFFF_F000;
    localparam logic [63:0] Z   = 64'd0;

    typedef struct packed {
        logic        en;
        logic        smt;
        logic [7:0]  bus;
        logic [7:0]  devfn;
        logic [63:0] rlo;
        logic [63:0] rhi;
        logic [63:0] c0;
        logic [63:0] c1;
        logic [63:0] c2;
        logic [63:0] c3;
        logic        rerr;
        logic        cerr;
        logic        pok;
        logic [3:0]  exp;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,8'd3, 8'h12,TA|64'd1,Z,L0,L1,Z,Z,1'b0,1'b0,1'b1,4'd0},          // R5 legacy ok
        '{1'b0,1'b0,8'd4, 8'h12,TA,Z,L0,L1,Z,Z,1'b0,1'b0,1'b1,4'd2},                // R8 root np
        '{1'b0,1'b0,8'd5, 8'h12,TA|64'd1,64'd1,L0,L1,Z,Z,1'b0,1'b0,1'b1,4'd3},      // R6 hi nonzero
        '{1'b0,1'b0,8'd6, 8'h12,TA|64'h21,Z,L0,L1,Z,Z,1'b0,1'b0,1'b1,4'd3},         // R6 lo bit 5
        '{1'b0,1'b0,8'd7, 8'h12,TA|64'd1,Z,L0,L1,Z,Z,1'b1,1'b0,1'b1,4'd1},          // R8 root read err
        '{1'b0,1'b0,8'd7, 8'h12,TA,Z,L0,L1,Z,Z,1'b1,1'b0,1'b1,4'd1},                // R8 err beats np
        '{1'b0,1'b0,8'd8, 8'h12,TA|64'd1,Z,L0,L1,Z,Z,1'b0,1'b1,1'b1,4'd4},          // R8 ctx read err
        '{1'b0,1'b0,8'd8, 8'h12,TA|64'd1,Z,64'h40_0000,L1,Z,Z,1'b0,1'b0,1'b1,4'd5}, // R8 ctx np
        '{1'b0,1'b0,8'd8, 8'h12,TA|64'd1,Z,L0,L1|(64'd1<<40),Z,Z,1'b0,1'b0,1'b1,4'd6}, // R7
        '{1'b0,1'b0,8'd8, 8'h12,TA|64'd1,Z,L0,64'h500,Z,Z,1'b0,1'b0,1'b1,4'd7},     // R9 level
        '{1'b0,1'b0,8'd8, 8'h12,TA|64'd1,Z,64'h40_000D,L1,Z,Z,1'b0,1'b0,1'b1,4'd7}, // R9 type 3
        '{1'b0,1'b0,8'd8, 8'h12,TA|64'd1,Z,64'h40_0009,L1,Z,Z,1'b0,1'b0,1'b1,4'd0}, // R9 type 2
        '{1'b1,1'b1,8'd9, 8'h85,Z,TB|64'd1,S0,Z,Z,Z,1'b0,1'b0,1'b1,4'd0},           // R4 hi half
        '{1'b1,1'b1,8'd9, 8'h05,Z,TB|64'd1,S0,Z,Z,Z,1'b0,1'b0,1'b1,4'd2},           // R4 lo half np
        '{1'b1,1'b1,8'd9, 8'h85,Z,TB|64'd1,S0,Z,64'd1,Z,1'b0,1'b0,1'b1,4'd6},       // R7 word2
        '{1'b1,1'b1,8'd9, 8'h85,Z,TB|64'd1,S0,Z,Z,Z,1'b0,1'b0,1'b0,4'd8},           // R10 refused
        '{1'b1,1'b0,8'd10,8'h85,TA|64'd1,Z,L0,L1,Z,Z,1'b0,1'b0,1'b1,4'd0},          // R2 smt off
        '{1'b0,1'b1,8'd10,8'h85,TA|64'd1,TB|64'd1,L0,L1,Z,Z,1'b0,1'b0,1'b1,4'd3},   // R2 enable off
        '{1'b1,1'b1,8'd11,8'h85,Z,TB|64'd5,S0,Z,Z,Z,1'b0,1'b0,1'b1,4'd3},           // R6 scalable
        '{1'b1,1'b1,8'd11,8'h05,TA|64'd1,Z,S0,Z,Z,Z,1'b0,1'b0,1'b1,4'd0},           // R5 32-byte slot
        '{1'b1,1'b1,8'd12,8'h85,Z,TB|64'd1,64'h50_0000,Z,Z,Z,1'b0,1'b0,1'b1,4'd5},  // R8 scal np
        '{1'b1,1'b1,8'd12,8'h85,Z,TB|64'd1,S0,64'h10_0000,Z,Z,1'b0,1'b0,1'b1,4'd6}  // R7 word1
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rtaddr_we = 1'b0;
    logic [63:0] rtaddr_wdata = '0;
    logic [63:0] rtaddr_rdata;
    logic        root_latch = 1'b0;
    logic        sm_enable = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_bus = '0;
    logic [7:0]  req_devfn = '0;
    logic        mem_rd_valid;
    logic [63:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        mem_rsp_err = 1'b0;
    logic        pchk_valid;
    logic        pchk_done = 1'b0;
    logic        pchk_ok = 1'b0;
    logic        rsp_valid;
    logic [3:0]  rsp_fault;
    logic [63:0] rsp_ctx_lo, rsp_ctx_hi;
    logic        rsp_scalable;
    logic [3:0]  rsp_level;
    logic [6:0]  rsp_width;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [63:0] mem [logic [63:0]];
    bit          errmap [logic [63:0]];
    bit          pok_cfg = 1'b1;
    logic        pend = 1'b0;
    logic        outst = 1'b0;
    logic [63:0] pend_addr = '0;

    logic [3:0]  got_fault;
    logic [63:0] got_lo, got_hi;
    logic        got_scal;
    logic [3:0]  got_level;
    logic [6:0]  got_width;

    ctx_entry_fetcher u_dut (
        .clk(clk), .rst_n(rst_n), .rtaddr_we(rtaddr_we), .rtaddr_wdata(rtaddr_wdata),
        .rtaddr_rdata(rtaddr_rdata), .root_latch(root_latch), .sm_enable(sm_enable),
        .req_valid(req_valid), .req_ready(req_ready), .req_bus(req_bus),
        .req_devfn(req_devfn), .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .mem_rsp_err(mem_rsp_err), .pchk_valid(pchk_valid), .pchk_done(pchk_done),
        .pchk_ok(pchk_ok), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_ctx_lo(rsp_ctx_lo), .rsp_ctx_hi(rsp_ctx_hi), .rsp_scalable(rsp_scalable),
        .rsp_level(rsp_level), .rsp_width(rsp_width)
    );

    always #2.5 clk = ~clk;

    task automatic check_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Memory model: one-cycle gap, answers each read once; R3 order checks.
    always @(negedge clk) begin
        if (mem_rsp_valid) mem_rsp_valid <= 1'b0;
        if (pend) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mem.exists(pend_addr) ? mem[pend_addr] : 64'd0;
            mem_rsp_err   <= errmap.exists(pend_addr);
            pend          <= 1'b0;
            outst         <= 1'b0;
        end
        if (rst_n && mem_rd_valid) begin
            checks++;
            if (outst || mem_rd_addr[2:0] != 3'd0) begin
                failures++;
                $display("FAIL R3 actual=%0h expected=aligned single read", mem_rd_addr);
            end
            pend_addr <= mem_rd_addr;
            pend      <= 1'b1;
            outst     <= 1'b1;
        end
    end

    // External check model for R10: answers one cycle after the request.
    always @(negedge clk) begin
        pchk_done <= pchk_valid && !pchk_done;
        pchk_ok   <= pok_cfg;
    end

    task automatic write_reg(input logic [63:0] v);
        @(negedge clk); rtaddr_we = 1'b1; rtaddr_wdata = v;
        @(negedge clk); rtaddr_we = 1'b0;
    endtask

    task automatic latch_ptr();
        @(negedge clk); root_latch = 1'b1;
        @(negedge clk); root_latch = 1'b0;
    endtask

    task automatic run_lookup(input logic [7:0] bus, input logic [7:0] devfn, input bit with_latch);
        int n;
        @(negedge clk);
        req_bus = bus; req_devfn = devfn; req_valid = 1'b1; root_latch = with_latch;
        @(negedge clk);
        req_valid = 1'b0; root_latch = 1'b0;
        n = 0;
        while (!rsp_valid && n < 2000) begin @(negedge clk); n++; end
        if (n >= 2000) check_eq("R8 lookup timeout", 64'd0, 64'd1);
        got_fault = rsp_fault; got_lo = rsp_ctx_lo; got_hi = rsp_ctx_hi;
        got_scal  = rsp_scalable; got_level = rsp_level; got_width = rsp_width;
    endtask

    function automatic string tag_of(input logic [3:0] f);
        case (f)
            4'd0: return "R5";
            4'd3: return "R6";
            4'd6: return "R7";
            4'd7: return "R9";
            4'd8: return "R10";
            default: return "R8";
        endcase
    endfunction

    // Places one vector's entries in memory, computing the addresses from R3-style rules.
    task automatic load_vec(input vec_t v);
        logic        scal;
        logic [63:0] half, cbase, raddr;
        logic [7:0]  ix;
        mem.delete(); errmap.delete();
        scal  = v.en & v.smt;
        raddr = RB + {52'd0, v.bus, 4'd0};
        mem[raddr] = v.rlo; mem[raddr + 8] = v.rhi;
        if (v.rerr) errmap[raddr + 8] = 1'b1;
        half  = (scal && v.devfn[7]) ? v.rhi : v.rlo;
        ix    = (scal && v.devfn[7]) ? {1'b0, v.devfn[6:0]} : v.devfn;
        cbase = (half & PM) + (scal ? {51'd0, ix, 5'd0} : {52'd0, ix, 4'd0});
        mem[cbase] = v.c0; mem[cbase + 8] = v.c1;
        if (scal) begin mem[cbase + 16] = v.c2; mem[cbase + 24] = v.c3; end
        if (v.cerr) errmap[cbase + 8] = 1'b1;
        pok_cfg = v.pok;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 and R11: reset state.
        check_eq("R1 reset register", rtaddr_rdata, 64'd0);
        check_eq("R11 reset ready", {63'd0, req_ready}, 64'd1);
        check_eq("R11 reset rsp_valid", {63'd0, rsp_valid}, 64'd0);
        check_eq("R3 reset read idle", {63'd0, mem_rd_valid}, 64'd0);
        @(negedge clk); rst_n = 1'b1;

        // R1: low ten bits read zero, the rest follow the write.
        write_reg(64'hFFFF_FFFF_FFFF_FFFF);
        check_eq("R1 writable bits", rtaddr_rdata, 64'hFFFF_FFFF_FFFF_FC00);

        // Vector walk covering R2, R4 to R10.
        for (int i = 0; i < NV; i++) begin
            logic scal;
            scal = VECS[i].en & VECS[i].smt;
            load_vec(VECS[i]);
            sm_enable = VECS[i].en;
            write_reg(RB | ({63'd0, VECS[i].smt} << 10));
            latch_ptr();
            run_lookup(VECS[i].bus, VECS[i].devfn, 1'b0);
            check_eq($sformatf("%s fault vec %0d", tag_of(VECS[i].exp), i), {60'd0, got_fault}, {60'd0, VECS[i].exp});
            check_eq($sformatf("R2 mode vec %0d", i), {63'd0, got_scal}, {63'd0, scal});
            if (VECS[i].exp == 4'd0) begin
                check_eq($sformatf("R5 word0 vec %0d", i), got_lo, VECS[i].c0);
                check_eq($sformatf("R5 word1 vec %0d", i), got_hi, VECS[i].c1);
                if (!scal) begin
                    check_eq($sformatf("R9 level vec %0d", i), {60'd0, got_level}, 64'd2 + {61'd0, VECS[i].c1[2:0]});
                    check_eq($sformatf("R9 width vec %0d", i), {57'd0, got_width}, 64'd30 + 64'd9 * {61'd0, VECS[i].c1[2:0]});
                end
            end
        end

        // R11: result lasts one cycle and the block is ready again.
        @(negedge clk);
        check_eq("R11 pulse ends", {63'd0, rsp_valid}, 64'd0);
        check_eq("R11 ready after result", {63'd0, req_ready}, 64'd1);

        // R2: latch in the same cycle as acceptance affects only the next lookup.
        mem.delete(); errmap.delete();
        mem[RB + 64'h130] = TA | 64'd1;
        mem[RB + 64'h138] = TB | 64'd1;
        mem[TB + 64'hA0] = S0; mem[TB + 64'hA8] = 64'd0;
        mem[TB + 64'hB0] = 64'd0; mem[TB + 64'hB8] = 64'd0;
        pok_cfg = 1'b1; sm_enable = 1'b0;
        write_reg(RB); latch_ptr();
        sm_enable = 1'b1;
        write_reg(RB | 64'h400);
        run_lookup(8'd19, 8'h85, 1'b1);
        check_eq("R2 same-cycle old mode fault", {60'd0, got_fault}, 64'd3);
        check_eq("R2 same-cycle old mode flag", {63'd0, got_scal}, 64'd0);
        run_lookup(8'd19, 8'h85, 1'b0);
        check_eq("R2 next lookup new mode fault", {60'd0, got_fault}, 64'd0);
        check_eq("R2 next lookup new mode flag", {63'd0, got_scal}, 64'd1);
        check_eq("R4 high half word0", got_lo, S0);

        // R2: register writes alone do not change the latched mode.
        write_reg(RB);
        run_lookup(8'd19, 8'h85, 1'b0);
        check_eq("R2 unlatched write ignored", {63'd0, got_scal}, 64'd1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule